// File: doc/BRIEF.md
# Ripple Magnitude Comparator

This block compares two unsigned operands of equal width. It raises exactly one of three flags: greater, equal or less. The comparison is made by a row of identical one-bit cells. The cell at the most significant position starts from a fixed "equal" verdict. Each cell hands a 2-bit relation code to its less significant neighbour. The code left after bit 0 is turned into the three flags by a small decoder.

A cell sees only its own pair of operand bits and the code that summarises every more significant bit. Any width is therefore built by adding cells, and the cell itself never changes. The block has no state and no clock. The result settles after a path that grows with the width, one cell delay per bit.

Top module: `magcmp_ripple`

## Requirements
- R1: `gt_o` is high exactly when `a_i` > `b_i`, with both operands read as unsigned integers (bit 0 least significant).
- R2: For every operand pair, exactly one of `gt_o`, `eq_o`, `lt_o` is high.
- R3: `eq_o` is high exactly when `a_i` == `b_i`, and `lt_o` is high exactly when `a_i` < `b_i`.
- R4: The relation code is 2 bits: 2'b00 means less, 2'b01 means equal, 2'b10 means greater. A cell that receives any code other than equal passes it on unchanged. A cell that receives equal outputs greater when its bits are a=1,b=0, less when they are a=0,b=1, and equal otherwise. As a result, a difference at a more significant bit always decides over any difference at a less significant bit.
- R5: No cell ever produces code 2'b11 from a valid incoming code, so the flags are never all low at the top.
- R6: The code entering the most significant cell is equal (2'b01). Operand pairs with no differing bit therefore report equal.
- R7: When the decoder receives code 2'b11, it drives all three flags low.
- R8: The width is the parameter `WIDTH` (at least 1). The cell row is generated from it, and the behaviour above holds for widths 1, 4, 6 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| gt_o | output | 1 | High when a_i > b_i |
| eq_o | output | 1 | High when a_i == b_i |
| lt_o | output | 1 | High when a_i < b_i |

## Verification
Two effects can meet in the same evaluation: a cell passing on a verdict that was already settled higher up, and a lower cell whose own bits point the opposite way. For example, with 0x80 against 0x7F, the top bit says greater and every lower bit says less. Such pairs come up throughout the exhaustive sweeps at widths 4 and 6, and directed pairs at width 8 force them explicitly. Each result is judged against the arithmetic relation that the bench computes from the operand values.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
    typedef enum logic [1:0] {
        REL_LT  = 2'b00,
        REL_EQ  = 2'b01,
        REL_GT  = 2'b10,
        REL_BAD = 2'b11
    } rel_e;
endpackage

// File: rtl/magcmp_slice.sv
module magcmp_slice
    import magcmp_pkg::*;
(
    input  logic a_bit,
    input  logic b_bit,
    input  rel_e rel_hi,
    output rel_e rel_lo
);
    // Only an undecided verdict may be refined by this bit pair (R4).
    always_comb begin
        unique case (rel_hi)
            REL_EQ: begin
                if (a_bit && !b_bit)
                    rel_lo = REL_GT;
                else if (!a_bit && b_bit)
                    rel_lo = REL_LT;
                else
                    rel_lo = REL_EQ;
            end
            REL_LT:  rel_lo = REL_LT;
            REL_GT:  rel_lo = REL_GT;
            REL_BAD: rel_lo = REL_BAD;
        endcase
    end

    always_comb begin
        if (rel_hi != REL_BAD)
            a_r5_no_bad: assert (rel_lo != REL_BAD)
                else $error("slice produced invalid code");
        if (rel_hi == REL_EQ && a_bit == b_bit)
            a_r4_tie_keeps: assert (rel_lo == REL_EQ)
                else $error("slice broke a tie on equal bits");
    end
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output rel_e             rel_o
);
    localparam int TAPS = WIDTH + 1;

    rel_e link [TAPS];

    // Seed at the most significant end (R6).
    assign link[WIDTH] = REL_EQ;

    // One identical cell per bit (R8).
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        magcmp_slice u_cell (
            .a_bit  (a_i[gi]),
            .b_bit  (b_i[gi]),
            .rel_hi (link[gi+1]),
            .rel_lo (link[gi])
        );
    end

    assign rel_o = link[0];
endmodule

// File: rtl/magcmp_decode.sv
module magcmp_decode
    import magcmp_pkg::*;
(
    input  rel_e rel_i,
    output logic gt_o,
    output logic eq_o,
    output logic lt_o
);
    always_comb begin
        unique case (rel_i)
            REL_GT:  {gt_o, eq_o, lt_o} = 3'b100;
            REL_EQ:  {gt_o, eq_o, lt_o} = 3'b010;
            REL_LT:  {gt_o, eq_o, lt_o} = 3'b001;
            REL_BAD: {gt_o, eq_o, lt_o} = 3'b000;
        endcase
    end

    always_comb begin
        if (rel_i == REL_BAD)
            a_r7_bad_silent: assert (!gt_o && !eq_o && !lt_o)
                else $error("decoder raised a flag on invalid code");
    end
endmodule

// File: rtl/magcmp_ripple.sv
module magcmp_ripple
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             gt_o,
    output logic             eq_o,
    output logic             lt_o
);
    rel_e rel_final;

    magcmp_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i   (a_i),
        .b_i   (b_i),
        .rel_o (rel_final)
    );

    magcmp_decode u_dec (
        .rel_i (rel_final),
        .gt_o  (gt_o),
        .eq_o  (eq_o),
        .lt_o  (lt_o)
    );

    always_comb begin
        a_r2_onehot: assert ($onehot({gt_o, eq_o, lt_o}))
            else $error("flags not one-hot");
        a_r3_eq_match: assert (eq_o == (a_i == b_i))
            else $error("equal flag disagrees with operands");
    end
endmodule

// File: tb/magcmp_ripple_tb.sv
module magcmp_ripple_tb;
    import magcmp_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    logic [0:0] a1 = '0, b1 = '0;
    logic [3:0] a4 = '0, b4 = '0;
    logic [5:0] a6 = '0, b6 = '0;
    logic [7:0] a8 = '0, b8 = '0;
    logic g1, e1, l1, g4, e4, l4, g6, e6, l6, g8, e8, l8;
    rel_e dcode = REL_EQ;
    logic dg, de, dl;

    // Widths 1, 4, 6 and 8 (R8).
    magcmp_ripple #(.WIDTH(4)) u_dut (.a_i(a4), .b_i(b4), .gt_o(g4), .eq_o(e4), .lt_o(l4));
    magcmp_ripple #(.WIDTH(1)) u_dut1 (.a_i(a1), .b_i(b1), .gt_o(g1), .eq_o(e1), .lt_o(l1));
    magcmp_ripple #(.WIDTH(6)) u_dut6 (.a_i(a6), .b_i(b6), .gt_o(g6), .eq_o(e6), .lt_o(l6));
    magcmp_ripple #(.WIDTH(8)) u_dut8 (.a_i(a8), .b_i(b8), .gt_o(g8), .eq_o(e8), .lt_o(l8));
    magcmp_decode u_dec (.rel_i(dcode), .gt_o(dg), .eq_o(de), .lt_o(dl));

    task automatic chk(input string req, input int w, input int a, input int b,
                       input logic g, input logic e, input logic l);
        logic [2:0] exp;
        exp = (a > b) ? 3'b100 : (a == b) ? 3'b010 : 3'b001;
        vecs++;
        if ({g, e, l} !== exp) begin
            errs++;
            $display("FAIL %s w=%0d a=%0d b=%0d got gel=%b expected gel=%b",
                     req, w, a, b, {g, e, l}, exp);
        end
        // R2 R5: exactly one flag, never all low
        vecs++;
        if ($countones({g, e, l}) != 1) begin
            errs++;
            $display("FAIL R2 R5 w=%0d a=%0d b=%0d got gel=%b expected one-hot",
                     w, a, b, {g, e, l});
        end
    endtask

    function automatic string tag(input int a, input int b);
        if (a == b) return "R6 R3";
        return (a > b) ? "R1" : "R3";
    endfunction

    initial begin
        // Reset state: operands zero report equal (R6).
        @(negedge clk);
        chk("R6 reset", 4, a4, b4, g4, e4, l4);

        // Exhaustive widths 6 and 4, plus 1; random width 8 (R1 R3 R8).
        for (int i = 0; i < 4096; i++) begin
            @(posedge clk);
            a6 = i[11:6]; b6 = i[5:0];
            a4 = i[9:6];  b4 = i[3:0];
            a1 = i[6];    b1 = i[0];
            a8 = 8'($urandom); b8 = (i % 7 == 0) ? a8 : 8'($urandom);
            @(negedge clk);
            chk(tag(a6, b6), 6, a6, b6, g6, e6, l6);
            chk(tag(a4, b4), 4, a4, b4, g4, e4, l4);
            chk(tag(a1, b1), 1, a1, b1, g1, e1, l1);
            chk(tag(a8, b8), 8, a8, b8, g8, e8, l8);
        end

        // R4: high-order difference overrides opposite low-order bits.
        begin
            int pa [8] = '{8'h80, 8'h7F, 8'hFF, 8'hFE, 8'h00, 8'hFF, 8'h01, 8'hAA};
            int pb [8] = '{8'h7F, 8'h80, 8'hFE, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h55};
            for (int k = 0; k < 8; k++) begin
                @(posedge clk);
                a8 = 8'(pa[k]); b8 = 8'(pb[k]);
                @(negedge clk);
                chk("R4", 8, a8, b8, g8, e8, l8);
            end
        end

        // R7: decoder on every code, including the invalid one.
        for (int c = 0; c < 4; c++) begin
            logic [2:0] exp;
            @(posedge clk);
            dcode = rel_e'(c[1:0]);
            @(negedge clk);
            exp = (c == 0) ? 3'b001 : (c == 1) ? 3'b010 : (c == 2) ? 3'b100 : 3'b000;
            vecs++;
            if ({dg, de, dl} !== exp) begin
                errs++;
                $display("FAIL R7 code=%0d got gel=%b expected gel=%b", c, {dg, de, dl}, exp);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule